// File: doc/BRIEF.md
# Complementary Gate Pair with Dead-Band Insertion

This block turns a single PWM reference into two gate drive signals for a half bridge: a primary output that follows the reference and a secondary output that follows its inverse. Whenever the reference changes level, both gates are first driven inactive. The gate that is about to turn on waits out a programmable dead band, so the two switches of the bridge never conduct at the same time.

The dead band is counted by its own small prescaler and an 8-bit down counter. The prescaler divides the clock by 1, 2, 4 or 8, chosen by a 2-bit code. The counter sets how many divided ticks the dead band lasts. An enable input bypasses the dead band. In bypass the gates are simply the reference and its inverse, one register later. The reference generator and any fault or brake logic sit outside the block.

Top module: `cmpl_deadband`

## Requirements
- R1: The primary and secondary outputs are never high in the same cycle.
- R2: When the reference level differs from the level the block last sampled, the output that is currently high goes low at the very next rising clock edge.
- R3: With dead band enabled, a divider code d (0..3) and a count N from 1 to 255, a reference change sampled at edge E0 keeps both outputs low for exactly N*2^d clock cycles. At edge E0+N*2^d the output matching the new level goes high: the primary for a high reference, the secondary for a low reference.
- R4: With dead band enabled and N = 0, a reference change sampled at edge E0 drives the new output pair at E0 itself, with no cycle where both are low.
- R5: While the enable is low, at every edge the primary takes the sampled reference and the secondary takes its inverse. This includes an edge that falls inside an ongoing dead band, which ends that dead band at once.
- R6: A reference change that arrives before a dead band has ended restarts the full interval from that change. Neither output goes high in between.
- R7: The divider code and count are captured at the reference change. Changing them while the dead band runs does not alter its length.
- R8: During reset both outputs are low. The first edge after reset treats the current reference level as a fresh change, so a dead band is timed before either output turns on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwmRef | input | 1 | PWM reference waveform |
| dbEnable | input | 1 | 1 = insert dead band, 0 = bypass |
| dbDiv | input | 2 | Dead-band prescaler code, ratio 2^code |
| dbCount | input | 8 | Dead-band length in prescaled ticks |
| gatePri | output | 1 | Primary gate, high with the reference |
| gateSec | output | 1 | Secondary gate, high with the inverted reference |

## Verification
Two functions can claim the same edge: the end of a running dead band, and a new reference change that should restart it. The bench provokes this by toggling the reference again while a long interval is still counting. It then checks that both gates stay low through the whole restarted interval, and that only the gate for the latest level turns on, counted from the second change. A second collision drops the enable while a dead band is pending. There the bypass path must win at the next edge, with the gate pair taking the reference directly.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

  // Strobes from the control path to the dead-band timer datapath.
  typedef struct packed {
    logic load;   // capture divider/count and restart the interval
    logic run;    // a dead band is pending, advance the timer
  } dbStrobe_t;

endpackage

// File: rtl/deadband_timer.sv
module deadband_timer
  import deadband_pkg::*;
#(
  parameter int DIV_W = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dbStrobe_t        strobe,
  input  logic [DIV_W-1:0] divIn,
  input  logic [CNT_W-1:0] countIn,
  output logic             lastTick
);

  // Prescaler wide enough for the largest ratio 2^(2^DIV_W - 1).
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] divQ;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic [CNT_W-1:0] remain;
  logic             preWrap;

  // Terminal value of the prescaler: low divQ bits set.
  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign preMask[g] = (g < int'(divQ));
  end

  assign preWrap  = (preCnt == preMask);
  assign lastTick = strobe.run && preWrap && (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divQ   <= '0;
      preCnt <= '0;
      remain <= '0;
    end else if (strobe.load) begin
      divQ   <= divIn;
      preCnt <= '0;
      remain <= countIn;
    end else if (strobe.run) begin
      if (preWrap) begin
        preCnt <= '0;
        remain <= remain - CNT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/deadband_ctrl.sv
module deadband_ctrl
  import deadband_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwmRef,
  input  logic             dbEnable,
  input  logic [CNT_W-1:0] dbCount,
  input  logic             lastTick,
  output dbStrobe_t        strobe,
  output logic             gatePri,
  output logic             gateSec
);

  logic refQ;
  logic primed;
  logic deadPend;
  logic refChange;
  logic zeroCount;

  // Before the first edge after reset the sampled level is treated as new.
  assign refChange = !primed || (pwmRef != refQ);
  assign zeroCount = (dbCount == '0);

  assign strobe.load = dbEnable && refChange && !zeroCount;
  assign strobe.run  = deadPend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refQ     <= 1'b0;
      primed   <= 1'b0;
      deadPend <= 1'b0;
      gatePri  <= 1'b0;
      gateSec  <= 1'b0;
    end else begin
      primed <= 1'b1;
      refQ   <= pwmRef;
      if (!dbEnable) begin
        deadPend <= 1'b0;
        gatePri  <= pwmRef;
        gateSec  <= !pwmRef;
      end else if (refChange) begin
        if (zeroCount) begin
          deadPend <= 1'b0;
          gatePri  <= pwmRef;
          gateSec  <= !pwmRef;
        end else begin
          deadPend <= 1'b1;
          gatePri  <= 1'b0;
          gateSec  <= 1'b0;
        end
      end else if (deadPend && lastTick) begin
        deadPend <= 1'b0;
        gatePri  <= refQ;
        gateSec  <= !refQ;
      end
    end
  end

endmodule

// File: rtl/cmpl_deadband.sv
module cmpl_deadband
  import deadband_pkg::*;
#(
  parameter int DIV_W = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwmRef,
  input  logic             dbEnable,
  input  logic [DIV_W-1:0] dbDiv,
  input  logic [CNT_W-1:0] dbCount,
  output logic             gatePri,
  output logic             gateSec
);

  dbStrobe_t strobe;
  logic      lastTick;

  deadband_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwmRef   (pwmRef),
    .dbEnable (dbEnable),
    .dbCount  (dbCount),
    .lastTick (lastTick),
    .strobe   (strobe),
    .gatePri  (gatePri),
    .gateSec  (gateSec)
  );

  deadband_timer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .divIn    (dbDiv),
    .countIn  (dbCount),
    .lastTick (lastTick)
  );

endmodule

// File: rtl/cmpl_deadband_chk.sv
module cmpl_deadband_chk (
  input logic clk,
  input logic rst_n,
  input logic pwmRef,
  input logic dbEnable,
  input logic gatePri,
  input logic gateSec
);

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(gatePri && gateSec)); // R1

  AST_PRI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (gatePri && !pwmRef) |=> !gatePri); // R2

  AST_SEC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (gateSec && pwmRef) |=> !gateSec); // R2

  AST_PRI_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gatePri) |-> $past(pwmRef)); // R3

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !dbEnable |=> (gatePri == $past(pwmRef)) && (gateSec == !$past(pwmRef))); // R5

endmodule

bind cmpl_deadband cmpl_deadband_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwmRef   (pwmRef),
  .dbEnable (dbEnable),
  .gatePri  (gatePri),
  .gateSec  (gateSec)
);

// File: tb/cmpl_deadband_bench.sv
module cmpl_deadband_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwmRef = 1'b0;
  logic       dbEnable = 1'b1;
  logic [1:0] dbDiv = '0;
  logic [7:0] dbCount = '0;
  logic       gatePri;
  logic       gateSec;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  cmpl_deadband u_cmpl_deadband (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwmRef   (pwmRef),
    .dbEnable (dbEnable),
    .dbDiv    (dbDiv),
    .dbCount  (dbCount),
    .gatePri  (gatePri),
    .gateSec  (gateSec)
  );

  always #5 clk = ~clk;

  // Gate pair encoding used by checks: 2 = primary high, 1 = secondary high, 0 = both low.
  typedef struct packed {
    logic        newRef;
    logic [1:0]  div;
    logic [7:0]  cnt;
    logic [10:0] lowCycles;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, 8'd3,   11'd3},
    '{1'b0, 2'd1, 8'd3,   11'd6},
    '{1'b1, 2'd2, 8'd5,   11'd20},
    '{1'b0, 2'd3, 8'd2,   11'd16},
    '{1'b1, 2'd0, 8'd0,   11'd0},
    '{1'b0, 2'd3, 8'd1,   11'd8},
    '{1'b1, 2'd1, 8'd0,   11'd0},
    '{1'b0, 2'd0, 8'd255, 11'd255},
    '{1'b1, 2'd3, 8'd255, 11'd2040}
  };

  function automatic int pairVal();
    return {30'd0, gatePri, gateSec};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Wait out lowCycles samples expecting both gates low, then expect the new gate.
  task automatic expectDead(input int lowCycles, input logic lvl, input string req);
    int firstBad = -1;
    int badVal = 0;
    for (int k = 1; k <= lowCycles; k++) begin
      step();
      if (pairVal() != 0 && firstBad < 0) begin
        firstBad = k;
        badVal = pairVal();
      end
    end
    check(firstBad < 0, req, badVal, 0);
    step();
    check(pairVal() == (lvl ? 2 : 1), req, pairVal(), lvl ? 2 : 1);
  endtask

  initial begin
    // R8: reset holds both gates low even with the reference high
    pwmRef = 1'b1;
    dbCount = 8'd2;
    repeat (3) step();
    check(pairVal() == 0, "R8 reset", pairVal(), 0);
    pwmRef = 1'b0;
    rst_n = 1'b1;
    // R8: first edge after reset starts a dead band of 2 cycles before the secondary
    expectDead(2, 1'b0, "R8 first edge");

    // R3 / R4 / R2 / R1: table of transitions
    for (int i = 0; i < NVEC; i++) begin
      pwmRef  = VECS[i].newRef;
      dbDiv   = VECS[i].div;
      dbCount = VECS[i].cnt;
      expectDead(int'(VECS[i].lowCycles), VECS[i].newRef,
                 (VECS[i].cnt == 0) ? "R4 table" : "R3 table");
    end
    // reference is now high, primary on

    // R6: toggle again while the dead band runs; restarts from the second change
    dbDiv = 2'd0;
    dbCount = 8'd10;
    pwmRef = 1'b0;
    repeat (3) step();
    check(pairVal() == 0, "R6 mid-interval", pairVal(), 0);
    pwmRef = 1'b1;
    expectDead(10, 1'b1, "R6 restart");

    // R7: divider and count altered mid-interval do not change the length (2*4 = 8)
    dbDiv = 2'd1;
    dbCount = 8'd4;
    pwmRef = 1'b0;
    step();
    step();
    dbDiv = 2'd3;
    dbCount = 8'd200;
    expectDead(6, 1'b0, "R7 captured");

    // R5: dropping enable inside a pending dead band hands the pair to the reference
    dbDiv = 2'd0;
    dbCount = 8'd50;
    pwmRef = 1'b1;
    repeat (2) step();
    check(pairVal() == 0, "R5 pending", pairVal(), 0);
    dbEnable = 1'b0;
    step();
    check(pairVal() == 2, "R5 bypass takeover", pairVal(), 2);

    // R5: bypass follows each reference level one edge later
    pwmRef = 1'b0;
    step();
    check(pairVal() == 1, "R5 bypass low", pairVal(), 1);
    pwmRef = 1'b1;
    step();
    check(pairVal() == 2, "R5 bypass high", pairVal(), 2);

    // R2: re-enable; next change drops the primary at once
    dbEnable = 1'b1;
    dbCount = 8'd4;
    step();
    check(pairVal() == 2, "R5 re-enable hold", pairVal(), 2);
    pwmRef = 1'b0;
    step();
    check(pairVal() == 0, "R2 drop", pairVal(), 0);
    expectDead(3, 1'b0, "R3 after re-enable");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule